// File: doc/BRIEF.md
# Control-Steered Token Selector

This block joins three token streams into one. A one-bit control stream decides, token by token, which of two data streams feeds the output. Each firing takes one control token and one data token from the stream that the control token names. It then sends that data word out unchanged. Tokens on the other data stream stay where they are and wait for a later control token that names them.

Every port uses a valid/ready handshake. The block can therefore sit between ordinary FIFO channels. A firing takes place only when three conditions hold together: the control token is present, the named data token is present, and the output channel can take a token. All consumption and the output acceptance happen in one clock cycle, so a firing is never left half done. There is no internal storage, and the datapath width is a parameter.

Top module: `tss_selector`

## Requirements
- R1: Each firing consumes exactly one control token. `ctl_ready` is high only in a cycle in which the output token is accepted (`out_valid && out_ready`).
- R2: A control token of value 1 selects stream A and a control token of value 0 selects stream B. The selected stream supplies the data token for that firing.
- R3: The unselected data stream is never consumed. Its ready stays low, and its queued tokens remain available for later firings.
- R4: A firing requires both the control token and the selected data token to be valid. If either is missing, `out_valid` is low and no input ready is raised.
- R5: When `out_ready` is low, no input is consumed, even if every needed token is present. `out_valid` still reflects whether a token is on offer.
- R6: The output data equals the consumed data token bit for bit. Over a run, the output sequence matches the control sequence applied to each data stream in arrival order.
- R7: While `rst` is high, `out_valid`, `ctl_ready`, `a_ready` and `b_ready` are all low, whatever the inputs do.
- R8: The control token and the data token of a firing are consumed in the same cycle in which the output token is accepted. No input handshake completes in any other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctl_valid | input | 1 | Control token present |
| ctl_ready | output | 1 | Control token consumed this cycle |
| ctl_bit | input | 1 | Control value: 1 selects A, 0 selects B |
| a_valid | input | 1 | Stream A token present |
| a_ready | output | 1 | Stream A token consumed this cycle |
| a_data | input | DW | Stream A token value |
| b_valid | input | 1 | Stream B token present |
| b_ready | output | 1 | Stream B token consumed this cycle |
| b_data | input | DW | Stream B token value |
| out_valid | output | 1 | Output token offered |
| out_ready | input | 1 | Downstream can accept a token |
| out_data | output | DW | Output token value |

## Verification
The bench offers a token on the unselected stream during every firing. A design that consumed both streams would raise `b_ready` on an A firing and would lose B tokens; the final queue counts expose this. It also withholds the selected data token while the other one is present. A design that fired on any data token would then emit a wrong word. Other tests hold `out_ready` low with all inputs present, where a leaky design would drop tokens, and assert reset with all inputs valid. A long run with gaps on every channel compares the full output order against the order predicted from the control sequence, so any reordering or skipped token is caught.

// File: rtl/tss_pkg.sv
package tss_pkg;

    typedef enum logic {
        ROUTE_B = 1'b0,
        ROUTE_A = 1'b1
    } route_e;

    typedef struct packed {
        logic ctl;
        logic a;
        logic b;
        logic sink;
    } avail_t;

    typedef struct packed {
        logic ctl;
        logic a;
        logic b;
    } take_t;

    function automatic route_e decode_route(input logic c);
        return c ? ROUTE_A : ROUTE_B;
    endfunction

endpackage

// File: rtl/tss_fire_rule.sv
module tss_fire_rule
    import tss_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  avail_t avail,
    input  route_e route,
    output take_t  take,
    output logic   offer
);
    logic data_here;
    logic fire;

    always_comb begin
        data_here = (route == ROUTE_A) ? avail.a : avail.b;
        offer     = !rst && avail.ctl && data_here;
        fire      = offer && avail.sink;
        take.ctl  = fire;
        take.a    = fire && (route == ROUTE_A);
        take.b    = fire && (route == ROUTE_B);
    end

    AST_ONE_DATA_STREAM: assert property (@(posedge clk) disable iff (rst)
        !(take.a && take.b));                                           // R3
    AST_CTL_WITH_DATA: assert property (@(posedge clk) disable iff (rst)
        take.ctl == (take.a || take.b));                                // R1
    AST_A_NEEDS_ALL: assert property (@(posedge clk) disable iff (rst)
        take.a |-> (avail.ctl && avail.a && avail.sink && route == ROUTE_A)); // R4
    AST_B_NEEDS_ALL: assert property (@(posedge clk) disable iff (rst)
        take.b |-> (avail.ctl && avail.b && avail.sink && route == ROUTE_B)); // R4
    AST_NO_TAKE_BLOCKED: assert property (@(posedge clk) disable iff (rst)
        !avail.sink |-> !(take.ctl || take.a || take.b));                // R5
    AST_RESET_QUIET: assert property (@(posedge clk)
        rst |-> !(offer || take.ctl || take.a || take.b));              // R7

endmodule

// File: rtl/tss_data_route.sv
module tss_data_route
    import tss_pkg::*;
#(
    parameter int DW = 16
) (
    input  route_e        route,
    input  logic [DW-1:0] a_word,
    input  logic [DW-1:0] b_word,
    output logic [DW-1:0] y_word
);
    for (genvar i = 0; i < DW; i++) begin : g_bit
        assign y_word[i] = (route == ROUTE_A) ? a_word[i] : b_word[i];
    end

endmodule

// File: rtl/tss_selector.sv
module tss_selector
    import tss_pkg::*;
#(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ctl_valid,
    output logic          ctl_ready,
    input  logic          ctl_bit,
    input  logic          a_valid,
    output logic          a_ready,
    input  logic [DW-1:0] a_data,
    input  logic          b_valid,
    output logic          b_ready,
    input  logic [DW-1:0] b_data,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_data
);
    avail_t avail;
    take_t  take;
    route_e route;
    logic   offer;

    always_comb begin
        avail.ctl  = ctl_valid;
        avail.a    = a_valid;
        avail.b    = b_valid;
        avail.sink = out_ready;
        route      = decode_route(ctl_bit);
    end

    tss_fire_rule u_rule (
        .clk   (clk),
        .rst   (rst),
        .avail (avail),
        .route (route),
        .take  (take),
        .offer (offer)
    );

    tss_data_route #(.DW(DW)) u_route (
        .route  (route),
        .a_word (a_data),
        .b_word (b_data),
        .y_word (out_data)
    );

    assign out_valid = offer;
    assign ctl_ready = take.ctl;
    assign a_ready   = take.a;
    assign b_ready   = take.b;

    AST_ATOMIC_FIRING: assert property (@(posedge clk) disable iff (rst)
        (ctl_valid && ctl_ready) == (out_valid && out_ready));          // R8
    AST_DATA_ONLY_IN_FIRING: assert property (@(posedge clk) disable iff (rst)
        ((a_valid && a_ready) || (b_valid && b_ready)) |-> (out_valid && out_ready)); // R8
    AST_ROUTE_MATCH: assert property (@(posedge clk) disable iff (rst)
        (ctl_ready && ctl_bit) |-> (a_ready && !b_ready));              // R2

endmodule

// File: tb/tb_tss_selector.sv
module tb_tss_selector;
    localparam int DW = 16;
    localparam time CLK_PERIOD = 10;
    localparam int N = 12;

    logic          clk = 1'b0;
    logic          rst;
    logic          ctl_valid, ctl_ready, ctl_bit;
    logic          a_valid, a_ready, b_valid, b_ready;
    logic [DW-1:0] a_data, b_data, out_data;
    logic          out_valid, out_ready;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tss_selector #(.DW(DW)) dut (
        .clk(clk), .rst(rst),
        .ctl_valid(ctl_valid), .ctl_ready(ctl_ready), .ctl_bit(ctl_bit),
        .a_valid(a_valid), .a_ready(a_ready), .a_data(a_data),
        .b_valid(b_valid), .b_ready(b_ready), .b_data(b_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic cv, input logic cb, input logic av,
                         input logic [DW-1:0] ad, input logic bv,
                         input logic [DW-1:0] bd, input logic orr);
        @(negedge clk);
        ctl_valid = cv; ctl_bit = cb; a_valid = av; a_data = ad;
        b_valid = bv; b_data = bd; out_ready = orr;
        #1;
    endtask

    function automatic logic [3:0] readies();
        return {out_valid, ctl_ready, a_ready, b_ready};
    endfunction

    task automatic t_reset();
        rst = 1'b1;
        drive(1, 1, 1, 16'h1111, 1, 16'h2222, 1);
        check(readies() == 4'b0000, "R7 reset quiet", readies(), 0);
        drive(1, 0, 1, 16'h1111, 1, 16'h2222, 1);
        check(readies() == 4'b0000, "R7 reset quiet ctl0", readies(), 0);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic t_route_a();
        drive(1, 1, 1, 16'hA5A5, 1, 16'h5A5A, 1);
        check(readies() == 4'b1110, "R2 R3 R8 route A handshakes", readies(), 4'b1110);
        check(out_data == 16'hA5A5, "R6 route A data", out_data, 16'hA5A5);
    endtask

    task automatic t_route_b();
        drive(1, 0, 1, 16'hA5A5, 1, 16'h5A5A, 1);
        check(readies() == 4'b1101, "R2 R3 route B handshakes", readies(), 4'b1101);
        check(out_data == 16'h5A5A, "R6 route B data", out_data, 16'h5A5A);
    endtask

    task automatic t_missing();
        drive(1, 1, 0, 16'h0, 1, 16'h7777, 1);
        check(readies() == 4'b0000, "R4 A missing, B present", readies(), 0);
        drive(1, 0, 1, 16'h6666, 0, 16'h0, 1);
        check(readies() == 4'b0000, "R4 B missing, A present", readies(), 0);
        drive(0, 1, 1, 16'h6666, 1, 16'h7777, 1);
        check(readies() == 4'b0000, "R4 R1 control missing", readies(), 0);
    endtask

    task automatic t_blocked();
        drive(1, 1, 1, 16'hBEEF, 1, 16'hCAFE, 0);
        check(readies() == 4'b1000, "R5 sink full, offer only", readies(), 4'b1000);
        check(out_data == 16'hBEEF, "R5 offered word", out_data, 16'hBEEF);
        drive(1, 0, 1, 16'hBEEF, 1, 16'hCAFE, 0);
        check(readies() == 4'b1000, "R5 sink full ctl0", readies(), 4'b1000);
    endtask

    task automatic t_stream();
        logic          cq [N];
        logic [DW-1:0] aq [N];
        logic [DW-1:0] bq [N+1];
        logic [DW-1:0] ex [N];
        int na = 0, nb = 0, ci = 0, ai = 0, bi = 0, oi = 0, bad = 0, cyc = 0;
        for (int k = 0; k < N; k++) begin
            cq[k] = ((k * 5 + 1) % 3) != 0;
            if (cq[k]) begin ex[k] = 16'hA000 + 16'(na); na++; end
            else       begin ex[k] = 16'hB000 + 16'(nb); nb++; end
        end
        for (int k = 0; k < N; k++) aq[k] = 16'hA000 + 16'(k);
        for (int k = 0; k <= N; k++) bq[k] = 16'hB000 + 16'(k);
        while (oi < N && cyc < 400) begin
            drive(ci < N, (ci < N) ? cq[ci] : 1'b0,
                  (ai < na) && (cyc % 4 != 1), (ai < N) ? aq[ai] : '0,
                  (bi < nb + 1) && (cyc % 5 != 2), bq[bi],
                  cyc % 3 != 0);
            if ((ctl_valid && ctl_ready) != (out_valid && out_ready)) bad++;
            if (out_valid && out_ready) begin
                check(out_data == ex[oi], "R6 stream order", out_data, ex[oi]);
                oi++;
            end
            if (ctl_valid && ctl_ready) ci++;
            if (a_valid && a_ready) ai++;
            if (b_valid && b_ready) bi++;
            cyc++;
        end
        check(bad == 0, "R8 R1 atomic consumption", bad, 0);
        check(oi == N, "R6 all tokens out", oi, N);
        check(ci == N, "R1 control count", ci, N);
        check(ai == na, "R3 A consumed count", ai, na);
        check(bi == nb, "R3 B consumed count, one left", bi, nb);
        drive(0, 0, 0, '0, 1, bq[bi], 1);
        check(readies() == 4'b0000, "R3 leftover B untouched", readies(), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; ctl_valid = 0; ctl_bit = 0; a_valid = 0; b_valid = 0;
        a_data = '0; b_data = '0; out_ready = 0;
        t_reset();
        t_route_a();
        t_route_b();
        t_missing();
        t_blocked();
        t_stream();
        rst = 1'b1;
        drive(1, 1, 1, 16'h1, 1, 16'h2, 1);
        check(readies() == 4'b0000, "R7 reset mid-run", readies(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule